// File: doc/BRIEF.md
# Maskable Sticky Interrupt Aggregator for a Network MAC

This block collects seven single-cycle event pulses from the transmit and receive engines of an Ethernet MAC and gives them to software through one interrupt line. Each pulse sets its own sticky pending bit. A mask register picks which pending bits may raise the interrupt. Pending bits are captured whether or not their mask bit is set. As a result, unmasking an event that is already pending raises the interrupt straight away.

Software sees two 32-bit registers on a simple register bus with address, write strobe, write data and read data. The pending register sits at offset 0x04. Writing ones to it clears the matching bits. The enable mask sits at offset 0x08 and is a plain read/write register. The interrupt output is registered. It follows the pending-and-enabled set with one cycle of delay.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the pending register and the mask register both read 0, and the interrupt output is low.
- R2: An event pulse sets its pending bit at the clock edge where the pulse is sampled. The bit positions are: transmit done 0, transmit error 1, receive done 2, receive error 3, frame dropped 4, transmit control 5, receive control 6.
- R3: A pending bit is set even while its mask bit is 0, and it stays set. It does not raise the interrupt while it is masked.
- R4: A write to offset 0x04 clears each pending bit whose write-data bit is 1. Bits written as 0 keep their value.
- R5: If an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the bit ends up set.
- R6: A write to offset 0x08 loads mask bits 6:0 from write-data bits 6:0. Bits 31:7 of both registers always read 0.
- R7: The interrupt output, one cycle after any cycle, equals the OR of (pending AND mask) in that cycle.
- R8: Writing a 1 to the mask bit of an already pending event raises the interrupt in the cycle after the mask write takes effect.
- R9: Reading a register has no side effect. A write to any offset other than 0x04 or 0x08 changes nothing, and a read of such an offset returns 0.
- R10: The interrupt falls one cycle after the last enabled pending bit is cleared or masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_i | input | 7 | Event pulses, one bit per event source |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The main check is a full sweep over all 128 mask values crossed with all 128 pending patterns. The expected interrupt level is computed as a nonzero AND, and each pattern is then cleared to confirm the line drops. This sweep separates a correct AND-reduction from an OR, from an inverted mask, and from a stuck or swapped bit. Directed sequences cover the rest:
- pulses on one bit at a time under a zero mask, which confirm the bit positions and that masked events still latch;
- an unmask of an already pending bit;
- partial clear writes, which show that zero bits are left alone;
- a pulse and a clear landing in the same cycle;
- writes and reads at unmapped offsets.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;

    localparam int unsigned EVT_COUNT   = 7;
    localparam int unsigned BUS_DW      = 32;
    localparam int unsigned BUS_AW      = 8;
    localparam logic [7:0]  OFS_PENDING = 8'h04;
    localparam logic [7:0]  OFS_ENABLE  = 8'h08;

    typedef enum int unsigned {
        EV_TX_DONE  = 0,
        EV_TX_ERR   = 1,
        EV_RX_DONE  = 2,
        EV_RX_ERR   = 3,
        EV_DROPPED  = 4,
        EV_TX_CTRL  = 5,
        EV_RX_CTRL  = 6
    } evt_pos_e;

endpackage

// File: rtl/evt_pending_reg.sv
`timescale 1ns/1ps
module evt_pending_reg #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] pend_o
);

    typedef struct packed {
        logic [N-1:0] pend;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_we) begin
            st_d.pend = st_q.pend & ~clr_bits;
        end
        st_d.pend = st_d.pend | evt_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    for (genvar b = 0; b < N; b++) begin : g_bit_chk
        p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[b] |=> st_q.pend[b]);
    end

    p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0 && !clr_we) |=> $stable(st_q.pend));

    p_clear_works_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0 && clr_we) |=> ((st_q.pend & $past(clr_bits)) == '0));

endmodule

// File: rtl/evt_enable_reg.sv
`timescale 1ns/1ps
module evt_enable_reg #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [N-1:0] wr_bits,
    output logic [N-1:0] en_o
);

    typedef struct packed {
        logic [N-1:0] en;
    } en_st_t;

    en_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.en = wr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = st_q.en;

    p_enable_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.en == $past(wr_bits)));

    p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.en));

endmodule

// File: rtl/evt_irq_out.sv
`timescale 1ns/1ps
module evt_irq_out #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] en_i,
    output logic         irq_o
);

    typedef struct packed {
        logic irq;
    } irq_st_t;

    irq_st_t      st_d, st_q;
    logic [N-1:0] live;

    always_comb begin
        live   = pend_i & en_i;
        st_d   = st_q;
        st_d.irq = |live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o = st_q.irq;

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & en_i) != '0) |=> st_q.irq);

    p_irq_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & en_i) == '0) |=> !st_q.irq);

endmodule

// File: rtl/evt_irq_ctrl.sv
`timescale 1ns/1ps
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int unsigned NUM_EVT  = EVT_COUNT,
    parameter int unsigned DATA_W   = BUS_DW,
    parameter int unsigned ADDR_W   = BUS_AW,
    parameter logic [ADDR_W-1:0] PEND_OFS = ADDR_W'(OFS_PENDING),
    parameter logic [ADDR_W-1:0] EN_OFS   = ADDR_W'(OFS_ENABLE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic              irq_o
);

    localparam int unsigned PAD_W = DATA_W - NUM_EVT;

    logic               sel_pend, sel_en;
    logic [NUM_EVT-1:0] pend_q, en_q;

    always_comb begin
        sel_pend = (bus_addr == PEND_OFS);
        sel_en   = (bus_addr == EN_OFS);
    end

    evt_pending_reg #(.N(NUM_EVT)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_we   (bus_we && sel_pend),
        .clr_bits (bus_wdata[NUM_EVT-1:0]),
        .pend_o   (pend_q)
    );

    evt_enable_reg #(.N(NUM_EVT)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && sel_en),
        .wr_bits (bus_wdata[NUM_EVT-1:0]),
        .en_o    (en_q)
    );

    evt_irq_out #(.N(NUM_EVT)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend_i (pend_q),
        .en_i   (en_q),
        .irq_o  (irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (sel_pend) begin
            bus_rdata = {{PAD_W{1'b0}}, pend_q};
        end else if (sel_en) begin
            bus_rdata = {{PAD_W{1'b0}}, en_q};
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pend_q == '0 && en_q == '0 && !irq_o));

    p_read_no_effect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we && evt_i == '0) |=> $stable(pend_q));

endmodule

// File: tb/evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  evt_i = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    evt_irq_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .evt_i     (evt_i),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic [6:0] e);
        bus_we    = we;
        bus_addr  = a;
        bus_wdata = d;
        evt_i     = e;
        @(negedge clk);
        bus_we    = 1'b0;
        bus_wdata = '0;
        evt_i     = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #(190000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h04, v); chk("R1 pending", v, 32'h0);
        rd(8'h08, v); chk("R1 mask", v, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);

        // R2 / R3 each event position latches under a zero mask
        for (int i = 0; i < 7; i++) begin
            cyc(1'b0, 8'h00, 32'h0, 7'(1 << i));
            rd(8'h04, v); chk("R2 bit position", v, 32'(1 << i));
            cyc(1'b0, 8'h00, 32'h0, 7'h0);
            chk("R3 masked no irq", {31'b0, irq_o}, 32'h0);
            rd(8'h04, v); chk("R3 stays set", v, 32'(1 << i));
            cyc(1'b1, 8'h04, 32'(1 << i), 7'h0);
        end

        // R8 unmask of pending bit
        cyc(1'b0, 8'h00, 32'h0, 7'h04);
        cyc(1'b0, 8'h00, 32'h0, 7'h0);
        cyc(1'b1, 8'h08, 32'h4, 7'h0);
        chk("R8 irq still low on mask write", {31'b0, irq_o}, 32'h0);
        cyc(1'b0, 8'h00, 32'h0, 7'h0);
        chk("R8 irq raised", {31'b0, irq_o}, 32'h1);

        // R4 zero bits keep value
        cyc(1'b1, 8'h04, 32'h0, 7'h0);
        rd(8'h04, v); chk("R4 write zero keeps", v, 32'h4);
        cyc(1'b1, 8'h04, 32'hFFFF_FF7B, 7'h0);
        rd(8'h04, v); chk("R4 other bits keep", v, 32'h4);
        chk("R4 irq held", {31'b0, irq_o}, 32'h1);
        cyc(1'b1, 8'h04, 32'h4, 7'h0);
        rd(8'h04, v); chk("R4 cleared", v, 32'h0);
        chk("R10 irq one more cycle", {31'b0, irq_o}, 32'h1);
        cyc(1'b0, 8'h00, 32'h0, 7'h0);
        chk("R10 irq fell after clear", {31'b0, irq_o}, 32'h0);

        // R10 masking drops irq
        cyc(1'b0, 8'h00, 32'h0, 7'h04);
        cyc(1'b0, 8'h00, 32'h0, 7'h0);
        chk("R7 irq up", {31'b0, irq_o}, 32'h1);
        cyc(1'b1, 8'h08, 32'h0, 7'h0);
        chk("R10 irq one more cycle after mask", {31'b0, irq_o}, 32'h1);
        cyc(1'b0, 8'h00, 32'h0, 7'h0);
        chk("R10 irq fell after mask", {31'b0, irq_o}, 32'h0);
        rd(8'h04, v); chk("R3 pending survives mask", v, 32'h4);

        // R5 set wins over clear
        cyc(1'b0, 8'h00, 32'h0, 7'h18);
        rd(8'h04, v); chk("R5 setup", v, 32'h1C);
        cyc(1'b1, 8'h04, 32'h18, 7'h08);
        rd(8'h04, v); chk("R5 set wins", v, 32'h0C);
        cyc(1'b1, 8'h04, 32'h7F, 7'h0);

        // R6 mask width and readback
        cyc(1'b1, 8'h08, 32'hFFFF_FFFF, 7'h0);
        rd(8'h08, v); chk("R6 mask upper zero", v, 32'h7F);
        cyc(1'b1, 8'h08, 32'h0000_0055, 7'h0);
        rd(8'h08, v); chk("R6 mask load", v, 32'h55);

        // R9 reads are side-effect free, other offsets ignored
        cyc(1'b0, 8'h00, 32'h0, 7'h22);
        rd(8'h04, v); rd(8'h04, v); rd(8'h04, v);
        chk("R9 repeated read", v, 32'h22);
        cyc(1'b1, 8'h0C, 32'hFFFF_FFFF, 7'h0);
        rd(8'h04, v); chk("R9 stray write pending", v, 32'h22);
        rd(8'h08, v); chk("R9 stray write mask", v, 32'h55);
        rd(8'h0C, v); chk("R9 unmapped read", v, 32'h0);
        cyc(1'b1, 8'h04, 32'h7F, 7'h0);
        cyc(1'b1, 8'h08, 32'h0, 7'h0);
        cyc(1'b0, 8'h00, 32'h0, 7'h0);

        // R7 full sweep of mask x pending
        for (int m = 0; m < 128; m++) begin
            for (int s = 0; s < 128; s++) begin
                cyc(1'b1, 8'h08, 32'(m), 7'h0);
                cyc(1'b0, 8'h00, 32'h0, 7'(s));
                cyc(1'b0, 8'h00, 32'h0, 7'h0);
                chk("R7 sweep irq", {31'b0, irq_o}, {31'b0, ((s & m) != 0)});
                cyc(1'b1, 8'h04, 32'h7F, 7'h0);
                cyc(1'b0, 8'h00, 32'h0, 7'h0);
                chk("R10 sweep drop", {31'b0, irq_o}, 32'h0);
            end
        end

        finish_run();
    end

endmodule